// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous host to an external asynchronous static RAM of 128K 16-bit words whose two byte lanes each have their own active-low strobe. The host hands over one request at a time with a valid/ready handshake: an address, a write flag, one enable bit per byte lane and write data. Reads come back on a response port as a single-cycle valid pulse together with the captured word. Byte lanes that were not enabled return zero.

On the memory side the controller drives active-low chip enable, output enable, write enable and one strobe per byte lane. It also drives the word address and a shared tristate data bus. Every pin comes straight from a flop. All memory timings are given as picosecond parameters and turned into whole clock cycles by rounding up, with at least one cycle per phase.

A write runs with output enable high and write enable low. The byte strobes open and close the actual write window. While write enable stays low, a further write can be accepted in the hold cycle, so a run of writes keeps write enable low throughout and the strobes frame each word. When the direction of the bus changes, the controller inserts a quiet turnaround in which every control pin is inactive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both strobes are high, req_ready is 1 and rsp_valid is 0.
- R2: A read holds chip enable and output enable low and write enable high for RD_CYC cycles. rsp_valid pulses for exactly one cycle on the RD_CYC-th rising edge after the accepting edge, or TURN_CYC edges later when a turnaround comes first.
- R3: Strobe bit i is low during a read exactly when req_be[i] is 1; bit 0 serves data bits 7:0 and bit 1 serves bits 15:8. Response lane i carries the bus lane sampled in the last read cycle when req_be[i] is 1, and zero otherwise.
- R4: During a write, output enable stays high and write enable stays low. The enabled strobes stay low for PULSE_CYC = max(WE_CYC, DS_CYC-1) cycles, the written data is stable on the bus for at least DS_CYC cycles up to the end of the strobe window, and the address does not change inside that window.
- R5: A write changes only the byte lanes whose enable bit is 1. A write with both enable bits 0 never lowers a strobe and leaves memory unchanged.
- R6: A write accepted in the hold cycle of a previous write keeps write enable low without a break. The strobes go high between the two words, so each word is written separately.
- R7: When a read follows a write, or a write follows a read, at least TURN_CYC cycles with chip enable, output enable, write enable and both strobes all high come before the new access starts.
- R8: Output enable and write enable are never low together, and output enable is high in the cycle before write enable falls.
- R9: req_ready is 1 only when the controller is idle or in the hold cycle of a write. It is 0 while a read, a turnaround or a write setup or strobe window is in progress.
- R10: Each cycle count is ceil(ps / CLK_PS) with a minimum of 1. This applies to RD_CYC (read access), WE_CYC (write pulse), DS_CYC (data setup) and TURN_CYC (bus turnaround).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte-lane enables, bit 0 = bits 7:0 |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data valid |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | DATA_W/8 | Byte-lane strobes, active low, bit 0 = bits 7:0 |
| mem_addr | output | ADDR_W | Memory word address |
| mem_dq | inout | DATA_W | Tristate data bus |

## Verification
The bench runs the controller on a 10 ns clock with these settings:
- 25 ns read access, giving 3 cycles.
- 12 ns write pulse, giving 2 cycles.
- 31 ns data setup, giving 4 cycles.
- 15 ns turnaround, giving 2 cycles.

With these values every phase counter runs past a single cycle. The data-setup demand, not the write-pulse demand, sets the strobe window (3 cycles), so a controller that ignores the setup term is caught. The two-cycle turnaround makes the quiet gap between read and write directly measurable.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_READ   = 3'd2,
        ST_WSET   = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_e;

    // Round a picosecond figure up to whole clock cycles, never below one.
    function automatic int ps_to_cycles(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // An expired timer stays expired until reloaded.
    AST_TMR_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done); // R10

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] bus,
    output logic [LANES*8-1:0] rdata,
    output logic               valid
);

    typedef struct packed {
        logic [LANES*8-1:0] rdata;
        logic               valid;
    } cap_t;

    cap_t               d, q;
    logic [LANES*8-1:0] lane_masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_masked[g*8 +: 8] = lane_en[g] ? bus[g*8 +: 8] : 8'h00;
    end

    always_comb begin
        d       = q;
        d.valid = capture;
        if (capture) begin
            d.rdata = lane_masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign valid = q.valid;

    AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R2

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 16,
    parameter int CLK_PS        = 10000,
    parameter int RD_ACCESS_PS  = 10000,
    parameter int WE_PULSE_PS   = 8000,
    parameter int DATA_SETUP_PS = 6000,
    parameter int BUS_TURN_PS   = 4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DATA_W/8-1:0] mem_bs_n,
    output logic [ADDR_W-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq
);

    localparam int LANES     = DATA_W / 8;
    localparam int RD_CYC    = ps_to_cycles(RD_ACCESS_PS, CLK_PS);
    localparam int WE_CYC    = ps_to_cycles(WE_PULSE_PS, CLK_PS);
    localparam int DS_CYC    = ps_to_cycles(DATA_SETUP_PS, CLK_PS);
    localparam int TURN_CYC  = ps_to_cycles(BUS_TURN_PS, CLK_PS);
    // One setup cycle precedes the strobe window, so the window covers the rest.
    localparam int PULSE_CYC = (WE_CYC > DS_CYC - 1) ? WE_CYC : DS_CYC - 1;
    localparam int MAX_A     = (RD_CYC > PULSE_CYC) ? RD_CYC : PULSE_CYC;
    localparam int MAX_CYC   = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctl_state_e         state;
        bus_op_e            last_op;
        logic               pend_wr;
        logic [ADDR_W-1:0]  addr;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wdata;
        logic               ce_n;
        logic               oe_n;
        logic               we_n;
        logic [LANES-1:0]   bs_n;
        logic               drv;
    } ctl_t;

    ctl_t             d, q;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap;

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap       = 1'b0;
        req_ready = (q.state == ST_IDLE) || (q.state == ST_WHOLD);
        accept    = req_valid && req_ready;

        if (accept) begin
            d.addr    = req_addr;
            d.be      = req_be;
            d.wdata   = req_wdata;
            d.pend_wr = req_write;
        end

        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        d.state = (q.last_op == OP_READ) ? ST_TURN : ST_WSET;
                    end else begin
                        d.state = (q.last_op == OP_WRITE) ? ST_TURN : ST_READ;
                    end
                end
            end
            ST_WHOLD: begin
                if (accept) begin
                    d.state = req_write ? ST_WSET : ST_TURN;
                end else begin
                    d.state = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (tmr_done) begin
                    d.state = q.pend_wr ? ST_WSET : ST_READ;
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    cap     = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_WSET: begin
                d.state = ST_WPULSE;
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    d.state = ST_WHOLD;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase

        if (d.state == ST_READ && q.state != ST_READ) begin
            d.last_op = OP_READ;
        end
        if (d.state == ST_WSET && q.state != ST_WSET) begin
            d.last_op = OP_WRITE;
        end

        if (d.state != q.state) begin
            tmr_load = 1'b1;
            case (d.state)
                ST_READ:   tmr_val = CNT_W'(RD_CYC - 1);
                ST_WPULSE: tmr_val = CNT_W'(PULSE_CYC - 1);
                ST_TURN:   tmr_val = CNT_W'(TURN_CYC - 1);
                default:   tmr_val = '0;
            endcase
        end

        // Pin values for the coming cycle, registered with the state.
        d.ce_n = 1'b1;
        d.oe_n = 1'b1;
        d.we_n = 1'b1;
        d.bs_n = '1;
        d.drv  = 1'b0;
        case (d.state)
            ST_READ: begin
                d.ce_n = 1'b0;
                d.oe_n = 1'b0;
                d.bs_n = ~d.be;
            end
            ST_WSET, ST_WHOLD: begin
                d.ce_n = 1'b0;
                d.we_n = 1'b0;
                d.drv  = 1'b1;
            end
            ST_WPULSE: begin
                d.ce_n = 1'b0;
                d.we_n = 1'b0;
                d.bs_n = ~d.be;
                d.drv  = 1'b1;
            end
            default: begin
                d.drv = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.last_op <= OP_NONE;
            q.ce_n    <= 1'b1;
            q.oe_n    <= 1'b1;
            q.we_n    <= 1'b1;
            q.bs_n    <= '1;
        end else begin
            q <= d;
        end
    end

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_capture #(
        .LANES(LANES)
    ) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .lane_en (q.be),
        .bus     (mem_dq),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    assign mem_ce_n = q.ce_n;
    assign mem_oe_n = q.oe_n;
    assign mem_we_n = q.we_n;
    assign mem_bs_n = q.bs_n;
    assign mem_addr = q.addr;
    assign mem_dq   = q.drv ? q.wdata : {DATA_W{1'bz}};

    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R8
    AST_WE_FALL_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_oe_n)); // R8
    AST_READ_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_ce_n) && $past(mem_we_n))); // R7
    AST_ADDR_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WPULSE && $past(q.state) == ST_WPULSE) |-> $stable(mem_addr)); // R4
    AST_READY_ONLY_QUIESCENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n || (!mem_we_n && (&mem_bs_n)))); // R9

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

    localparam int CLK_PS   = 10000;
    localparam int RD_PS    = 25000;
    localparam int WE_PS    = 12000;
    localparam int DS_PS    = 31000;
    localparam int TURN_PS  = 15000;

    function automatic int to_cyc(input int ps);
        int c;
        c = (ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RD    = to_cyc(RD_PS);
    localparam int E_WE    = to_cyc(WE_PS);
    localparam int E_DS    = to_cyc(DS_PS);
    localparam int E_TURN  = to_cyc(TURN_PS);
    localparam int E_PULSE = (E_WE > E_DS - 1) ? E_WE : E_DS - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_bs_n;
    logic [16:0] mem_addr;
    wire  [15:0] dq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #5ns clk = ~clk;

    sram_lane_ctrl #(
        .ADDR_W(17), .DATA_W(16), .CLK_PS(CLK_PS), .RD_ACCESS_PS(RD_PS),
        .WE_PULSE_PS(WE_PS), .DATA_SETUP_PS(DS_PS), .BUS_TURN_PS(TURN_PS)
    ) i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bs_n(mem_bs_n), .mem_addr(mem_addr), .mem_dq(dq)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [5:0] idx(input logic [16:0] a);
        return {a[16], a[4:0]};
    endfunction

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 40503) ^ 16'h5A5A;
    endfunction

    // Behavioural memory with byte lanes and tristate outputs.
    logic [15:0] marr [64];
    logic [15:0] sb   [64];
    logic [15:0] rd_word;

    always_comb rd_word = marr[idx(mem_addr)];

    assign dq[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bs_n[0]) ? rd_word[7:0]  : 8'hzz;
    assign dq[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_bs_n[1]) ? rd_word[15:8] : 8'hzz;

    // Pin monitor, sampled mid-cycle.
    int          ovl = 0, ds = 0, ds_at = 0, quiet = 0, last_acc = 0;
    int          commit_cnt = 0, we_rise = 0;
    bit          prev_act = 0, prev_wph = 0, moved = 0;
    logic        prev_oe = 1, prev_we = 1;
    logic [15:0] prev_dq = '0, w_data = '0;
    logic [16:0] w_addr = '0;
    logic [1:0]  w_bs = '1;

    always @(negedge clk) begin
        if (rst_n) begin
            bit act, wph, allhi;
            act   = !mem_ce_n && !mem_we_n && (mem_bs_n != 2'b11);
            wph   = !mem_ce_n && !mem_we_n && mem_oe_n;
            allhi = mem_ce_n && mem_oe_n && mem_we_n && (mem_bs_n == 2'b11);
            if (wph) ds = (prev_wph && dq == prev_dq) ? ds + 1 : 1;
            else     ds = 0;
            if (prev_oe && !mem_oe_n) begin
                check(mem_we_n, "R8 write enable high while output enable low", mem_we_n, 1);
                if (last_acc == 2)
                    check(quiet >= E_TURN, "R7 quiet cycles before read", quiet, E_TURN);
                last_acc = 1;
            end
            if (prev_we && !mem_we_n) begin
                check(prev_oe, "R8 output enable high before write enable falls", prev_oe, 1);
                if (last_acc == 1)
                    check(quiet >= E_TURN, "R7 quiet cycles before write", quiet, E_TURN);
                last_acc = 2;
            end
            if (!prev_we && mem_we_n) we_rise++;
            if (act) begin
                if (!prev_act) begin
                    ovl = 0; moved = 0; w_addr = mem_addr;
                end
                ovl++;
                if (mem_addr != w_addr) moved = 1;
                w_data = dq; w_bs = mem_bs_n; ds_at = ds;
            end
            if (prev_act && !act) begin
                check(ovl == E_PULSE, "R4 R10 strobe window length", ovl, E_PULSE);
                check(ds_at >= E_DS, "R4 data setup cycles", ds_at, E_DS);
                check(!moved, "R4 address stable in write window", moved, 0);
                if (!w_bs[0]) marr[idx(w_addr)][7:0]  = w_data[7:0];
                if (!w_bs[1]) marr[idx(w_addr)][15:8] = w_data[15:8];
                commit_cnt++;
            end
            quiet    = allhi ? quiet + 1 : 0;
            prev_act = act; prev_wph = wph; prev_dq = dq;
            prev_oe  = mem_oe_n; prev_we = mem_we_n;
        end
    end

    bit host_lastwr = 0;

    task automatic issue(input bit wr, input logic [16:0] a, input logic [1:0] be,
                         input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1ns req_valid = 0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [1:0] be, input logic [15:0] wd);
        issue(1, a, be, wd);
        if (be[0]) sb[idx(a)][7:0]  = wd[7:0];
        if (be[1]) sb[idx(a)][15:8] = wd[15:8];
        host_lastwr = 1;
    endtask

    task automatic do_read(input logic [16:0] a, input logic [1:0] be, input string tag);
        int lat, elat;
        logic [15:0] e;
        e    = {be[1] ? sb[idx(a)][15:8] : 8'h00, be[0] ? sb[idx(a)][7:0] : 8'h00};
        elat = E_RD + (host_lastwr ? E_TURN : 0);
        issue(0, a, be, 16'h0);
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!rsp_valid && lat < 50);
        check(lat == elat, {"R2 R7 R10 read latency ", tag}, lat, elat);
        check(rsp_rdata == e, {"R3 R5 read data ", tag}, rsp_rdata, e);
        @(negedge clk);
        check(!rsp_valid, {"R2 single-cycle valid ", tag}, rsp_valid, 0);
        host_lastwr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, r0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            marr[i] = init_val(i);
            sb[i]   = init_val(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 controls high after reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        check(mem_bs_n == 2'b11, "R1 strobes high after reset", mem_bs_n, 2'b11);
        check(req_ready && !rsp_valid, "R1 handshake after reset", {req_ready, rsp_valid}, 2'b10);

        do_read(17'd3, 2'b11, "initial word");
        do_write(17'd3, 2'b11, 16'hA1B2);
        @(negedge clk);
        check(!req_ready, "R9 busy during write setup", req_ready, 0);
        do_read(17'd3, 2'b11, "after full write");
        do_write(17'd3, 2'b01, 16'hFFEE);
        do_read(17'd3, 2'b11, "after lower-lane write");
        c0 = commit_cnt;
        do_write(17'd3, 2'b00, 16'h0000);
        do_read(17'd3, 2'b11, "after empty write");
        check(commit_cnt == c0, "R5 empty write commits nothing", commit_cnt, c0);
        do_read(17'd3, 2'b10, "upper lane only");
        do_read(17'd3, 2'b01, "read after read");

        r0 = we_rise; c0 = commit_cnt;
        do_write(17'd5, 2'b11, 16'h1357);
        do_write(17'd6, 2'b10, 16'h2468);
        repeat (10) @(negedge clk);
        check(we_rise - r0 == 1, "R6 write enable held across chained writes", we_rise - r0, 1);
        check(commit_cnt - c0 == 2, "R6 two separate word writes", commit_cnt - c0, 2);
        host_lastwr = 1;
        do_read(17'd5, 2'b11, "chained word 1");
        do_read(17'd6, 2'b11, "chained word 2");
        do_write(17'h1FFFF, 2'b11, 16'hC0DE);
        do_read(17'h1FFFF, 2'b11, "top address");

        for (int k = 0; k < 300; k++) begin
            logic [16:0] a;
            logic [1:0]  be;
            a  = {($urandom % 2) ? 12'hFFF : 12'h000, 5'($urandom)};
            be = 2'($urandom);
            if ($urandom % 2) do_write(a, be, 16'($urandom));
            else              do_read(a, be, "random");
        end

        repeat (5) @(negedge clk);
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule